// File: doc/BRIEF.md
# Probe Housekeeping Control and Sense Register

This block holds the housekeeping controls of a debug probe and collects the events it senses on the target side. Software changes the controls through two write offsets: one offset turns on every control bit that is 1 in the written mask, the other turns off every control bit that is 1 in the mask. Bits that are 0 in the mask keep their value, so no read-modify-write is needed and two software agents can touch different controls without a race. The controls drive the system reset and test reset lines towards the target, the target power switch, two indicator lamps and the choice between returned-clock pacing and the fixed clock divider.

Three sticky flags record events: a system reset seen on the target's reset line, a dip in target supply, and a returned-clock timeout reported by the scan engine. The two external sense lines are asynchronous and pass through a synchronizer chain first. A flag stays set until software rearms it; a sense event that arrives in the same cycle as the rearm wins, so no event is lost, and a level that is still present sets the flag again at once. Reading either write offset returns the control bits merged with the three flags.

The write and read side is a plain register access port with no handshake: a write takes effect on the clock edge where the write strobe is high, and read data is a combinational function of the address.

Top module: `probe_hk_csr`

## Requirements
- R1: After reset all control bits and all flags are 0: reset drives deasserted, target power enabled, both lamps off, divider pacing selected, and the status word reads 0.
- R2: A write at offset 0x10 (set port) turns on the control bits at positions 0, 1, 3, 4, 5 and 8 that are 1 in the mask; all other control bits keep their value, and cycles without a write keep every control output stable.
- R3: A write at offset 0x14 (clear port) turns off the control bits at positions 0, 1, 3, 4, 5 and 8 that are 1 in the mask; all other control bits keep their value.
- R4: Control bit 0 drives the system reset output and bit 1 the test reset output (1 = asserted); bit 3 = 1 switches target power off (power enable output is the inverse); bits 4 and 5 drive lamp outputs 0 and 1; bit 8 = 1 selects returned-clock pacing, 0 the divider.
- R5: A read at offset 0x10 or 0x14 returns the control bits at their positions, the system-reset flag at bit 6, the supply-dip flag at bit 7 and the clock-timeout flag at bit 10, and 0 at every other bit; a read at any other offset returns 0.
- R6: A high level on the system-reset sense input or the supply-dip sense input sets its flag on the third rising edge after the input rises (two synchronizer stages then the flag), and the flag stays set after the input falls.
- R7: Writing bit 6 (or bit 7) as 1 to the set port clears the system-reset (or supply-dip) flag; writing those bits to the clear port has no effect on the flags.
- R8: A high clock-timeout input sets the timeout flag on the next rising edge; writing bit 10 as 1 to the clear port clears it, while writing bit 10 to the set port has no effect.
- R9: When a flag's set event and its rearm or clear write fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset for write and read |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Status word read data |
| srst_sense | input | 1 | Asynchronous system reset seen on the target line (1 = asserted) |
| pwr_dip_sense | input | 1 | Asynchronous target supply dip indication |
| rclk_timeout | input | 1 | Synchronous returned-clock timeout pulse from the scan engine |
| srst_out | output | 1 | System reset drive (1 = assert) |
| trst_out | output | 1 | Test reset drive (1 = assert) |
| tgt_pwr_en | output | 1 | Target power switch enable |
| led_o | output | 2 | Indicator lamp drives |
| rclk_sel | output | 1 | 1 = returned-clock pacing, 0 = divider |

## Verification
The hardest situation to reach is a flag's set event landing on exactly the edge of its rearm write. For the external senses the bench holds the sense line high through the synchronizer delay so the synchronized level is present when the set-port rearm write strikes; for the timeout flag it raises the timeout pulse on the same half cycle it drives the clear-port write. Both checks read the status word afterwards and expect the flag still set.

// File: rtl/probe_hk_pkg.sv
package probe_hk_pkg;
  localparam int unsigned BIT_SRST   = 0;
  localparam int unsigned BIT_TRST   = 1;
  localparam int unsigned BIT_PWROFF = 3;
  localparam int unsigned BIT_LAMP0  = 4;
  localparam int unsigned BIT_LAMP1  = 5;
  localparam int unsigned BIT_SRSTF  = 6;
  localparam int unsigned BIT_DIPF   = 7;
  localparam int unsigned BIT_RCLK   = 8;
  localparam int unsigned BIT_TOF    = 10;

  localparam int unsigned NUM_FLAGS  = 3;
  localparam int unsigned NUM_SENSE  = 2;

  // flag index order inside the flag vector
  typedef enum logic [1:0] {
    FLG_SRST = 2'd0,
    FLG_DIP  = 2'd1,
    FLG_TO   = 2'd2
  } flag_idx_e;
endpackage

// File: rtl/hk_sync.sv
module hk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hk_sticky.sv
module hk_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic rearm_i,
  output logic flag_o
);
  logic flag_q;

  // the event term is ORed last so it wins over a rearm in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= event_i | (flag_q & ~rearm_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hk_ctrl_bank.sv
module hk_ctrl_bank #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] CTRL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] eff_mask;

  assign eff_mask = mask & CTRL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (set_en) ctrl_q <= ctrl_q | eff_mask;
    else if (clr_en) ctrl_q <= ctrl_q & ~eff_mask;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/probe_hk_csr.sv
module probe_hk_csr
  import probe_hk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              srst_sense,
  input  logic              pwr_dip_sense,
  input  logic              rclk_timeout,
  output logic              srst_out,
  output logic              trst_out,
  output logic              tgt_pwr_en,
  output logic [1:0]        led_o,
  output logic              rclk_sel
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
      (DATA_W'(1) << BIT_SRST)   | (DATA_W'(1) << BIT_TRST) |
      (DATA_W'(1) << BIT_PWROFF) | (DATA_W'(1) << BIT_LAMP0) |
      (DATA_W'(1) << BIT_LAMP1)  | (DATA_W'(1) << BIT_RCLK);

  logic              set_sel, clr_sel, set_hit, clr_hit;
  logic [DATA_W-1:0] ctrl;
  logic [NUM_SENSE-1:0] sense_raw, sense_sync;
  logic [NUM_FLAGS-1:0] flag_ev, flag_rearm, flag_q;
  logic [DATA_W-1:0] status;

  assign set_sel = (bus_addr == SET_OFS);
  assign clr_sel = (bus_addr == CLR_OFS);
  assign set_hit = bus_wr & set_sel;
  assign clr_hit = bus_wr & clr_sel;

  hk_ctrl_bank #(.DATA_W(DATA_W), .CTRL_MASK(CTRL_MASK)) bank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (set_hit),
    .clr_en (clr_hit),
    .mask   (bus_wdata),
    .ctrl_o (ctrl)
  );

  assign sense_raw = {pwr_dip_sense, srst_sense};

  for (genvar s = 0; s < NUM_SENSE; s++) begin : g_sync
    hk_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sense_raw[s]),
      .q     (sense_sync[s])
    );
  end

  // events and rearm sources per flag
  assign flag_ev[FLG_SRST]    = sense_sync[0];
  assign flag_ev[FLG_DIP]     = sense_sync[1];
  assign flag_ev[FLG_TO]      = rclk_timeout;
  assign flag_rearm[FLG_SRST] = set_hit & bus_wdata[BIT_SRSTF];
  assign flag_rearm[FLG_DIP]  = set_hit & bus_wdata[BIT_DIPF];
  assign flag_rearm[FLG_TO]   = clr_hit & bus_wdata[BIT_TOF];

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    hk_sticky sticky_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (flag_ev[f]),
      .rearm_i (flag_rearm[f]),
      .flag_o  (flag_q[f])
    );
  end

  always_comb begin
    status = ctrl;
    status[BIT_SRSTF] = flag_q[FLG_SRST];
    status[BIT_DIPF]  = flag_q[FLG_DIP];
    status[BIT_TOF]   = flag_q[FLG_TO];
  end

  assign bus_rdata  = (set_sel | clr_sel) ? status : '0;
  assign srst_out   = ctrl[BIT_SRST];
  assign trst_out   = ctrl[BIT_TRST];
  assign tgt_pwr_en = ~ctrl[BIT_PWROFF];
  assign led_o      = {ctrl[BIT_LAMP1], ctrl[BIT_LAMP0]};
  assign rclk_sel   = ctrl[BIT_RCLK];
endmodule

// File: rtl/probe_hk_csr_chk.sv
module probe_hk_csr_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rclk_timeout,
  input logic              srst_out,
  input logic              trst_out,
  input logic              tgt_pwr_en,
  input logic [1:0]        led_o,
  input logic              rclk_sel,
  input logic [2:0]        flags
);
  logic set_w, clr_w;
  assign set_w = bus_wr && (bus_addr == SET_OFS);
  assign clr_w = bus_wr && (bus_addr == CLR_OFS);

  a_r2_set_srst: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w && bus_wdata[0]) |=> srst_out);

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({srst_out, trst_out, tgt_pwr_en, led_o, rclk_sel}));

  a_r3_clr_trst: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && bus_wdata[1]) |=> !trst_out);

  a_r4_power_off: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w && bus_wdata[3]) |=> !tgt_pwr_en);

  a_r6_srst_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(set_w && bus_wdata[6])) |=> flags[0]);

  a_r7_dip_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !(set_w && bus_wdata[7])) |=> flags[1]);

  a_r8_timeout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !(clr_w && bus_wdata[10])) |=> flags[2]);

  a_r9_timeout_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_timeout |=> flags[2]);
endmodule

bind probe_hk_csr probe_hk_csr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .rclk_timeout (rclk_timeout),
  .srst_out     (srst_out),
  .trst_out     (trst_out),
  .tgt_pwr_en   (tgt_pwr_en),
  .led_o        (led_o),
  .rclk_sel     (rclk_sel),
  .flags        (flag_q)
);

// File: tb/probe_hk_csr_tb_top.sv
module probe_hk_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        srst_sense = 1'b0;
  logic        pwr_dip_sense = 1'b0;
  logic        rclk_timeout = 1'b0;
  logic        srst_out, trst_out, tgt_pwr_en, rclk_sel;
  logic [1:0]  led_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  probe_hk_csr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .srst_sense(srst_sense),
    .pwr_dip_sense(pwr_dip_sense), .rclk_timeout(rclk_timeout),
    .srst_out(srst_out), .trst_out(trst_out), .tgt_pwr_en(tgt_pwr_en),
    .led_o(led_o), .rclk_sel(rclk_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h10; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 8'h10;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h10, v);
    check("R1 status", v, 32'h0);
    check("R1 outputs", {27'b0, srst_out, trst_out, tgt_pwr_en, led_o, rclk_sel},
          {27'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0});
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    wr(8'h10, 32'h0000_0013);
    rd(8'h10, v);
    check("R2 set 0x13", v, 32'h13);
    check("R4 srst trst lamps", {28'b0, srst_out, trst_out, led_o}, {28'b0, 1'b1, 1'b1, 2'b01});
    wr(8'h10, 32'h0000_0108);
    rd(8'h14, v);
    check("R2 set keeps others", v, 32'h11B);
    check("R4 power off rclk", {30'b0, tgt_pwr_en, rclk_sel}, {30'b0, 1'b0, 1'b1});
    wr(8'h14, 32'h0000_0003);
    rd(8'h10, v);
    check("R3 clear mask only", v, 32'h118);
    check("R4 resets released", {30'b0, srst_out, trst_out}, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h10, v);
    check("R2 idle stable", v, 32'h118);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v);
    check("R2 only control bits", v, 32'h13B);
    rd(8'h18, v);
    check("R5 other offset reads 0", v, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h10, v);
    check("R3 clear all", v, 32'h0);
  endtask

  task automatic t_srst_sense;
    logic [31:0] v;
    @(negedge clk);
    srst_sense = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(8'h10, v);
    check("R6 not yet after two edges", v, 32'h0);
    @(negedge clk);
    rd(8'h10, v);
    check("R6 flag after third edge", v, 32'h40);
    // still high: rearm write coincides with synchronized event
    wr(8'h10, 32'h40);
    rd(8'h10, v);
    check("R9 sense wins over rearm", v, 32'h40);
    srst_sense = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h10, v);
    check("R6 flag sticky after input falls", v, 32'h40);
    wr(8'h14, 32'h40);
    rd(8'h10, v);
    check("R7 clear port leaves flag", v, 32'h40);
    wr(8'h10, 32'h40);
    rd(8'h10, v);
    check("R7 set port rearms", v, 32'h0);
  endtask

  task automatic t_dip_sense;
    logic [31:0] v;
    @(negedge clk);
    pwr_dip_sense = 1'b1;
    @(negedge clk);
    pwr_dip_sense = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h14, v);
    check("R6 dip flag latched", v, 32'h80);
    wr(8'h10, 32'h80);
    rd(8'h14, v);
    check("R7 dip rearm", v, 32'h0);
  endtask

  task automatic t_timeout;
    logic [31:0] v;
    @(negedge clk);
    rclk_timeout = 1'b1;
    @(negedge clk);
    rclk_timeout = 1'b0;
    rd(8'h10, v);
    check("R8 timeout flag next edge", v, 32'h400);
    wr(8'h10, 32'h400);
    rd(8'h10, v);
    check("R8 set port no effect", v, 32'h400);
    wr(8'h14, 32'h400);
    rd(8'h10, v);
    check("R8 clear port clears", v, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h400; rclk_timeout = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h10; bus_wdata = '0; rclk_timeout = 1'b0;
    rd(8'h10, v);
    check("R9 timeout wins over clear", v, 32'h400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_srst_sense();
    t_dip_sense();
    t_timeout();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule